// File: doc/BRIEF.md
# GPIO Port With Peripheral Overrides

This block is the control core of a parameterised general-purpose I/O port. For every pin it decides whether the pin drives, which source feeds the driver, and what value software sees when it reads the pin. It holds one direction register that software can read and write. It also provides a read-only view of the synchronized pin levels. Both are reached over a small register bus with address, write enable, write data and combinational read data.

Two peripherals can take pins away from software control. The first is an LCD segment driver, gated by a module enable and a per-pin enable. The second is a timer, whose output-compare channels take over pins while the timer module is enabled. Pins used for timer input capture simply stay under the direction register.

Each pin's output enable and a two-bit source select leave the block toward the pad logic. The analog waveforms, the timer counting, pull-ups and drive strength all sit outside this block.

Top module: `gpio_override_port`

## Requirements
- R1: A read at offset 1 returns, per bit, the pin level after a two-flop synchronizer. A pin change becomes visible after the second rising clock edge following it, provided no LCD ownership applies to that pin.
- R2: While `lcd_module_en` is 1 and `lcd_seg_en[i]` is 1, bit i of a read at offset 1 is 1, whatever the pin level.
- R3: Writes to offset 1 have no effect. The direction register and the offset-1 readback are unchanged.
- R4: The offset-1 readback is not reset. While `rst_n` is held low it still follows the synchronized pin levels.
- R5: The direction register is read and written at offset 2 and is WIDTH bits wide. After reset it reads all zeros, so every pin is an input. A write takes effect at the clock edge that samples it.
- R6: With no peripheral ownership, `pin_oe[i]` equals direction bit i and the source select for pin i is 2'b00 (software data).
- R7: While `lcd_module_en` and `lcd_seg_en[i]` are both 1, `pin_oe[i]` is 0, the source select is 2'b10 (LCD), and direction bit i has no effect. Clearing either enable returns the pin to its direction bit.
- R8: While `tmr_module_en` and `tmr_oc_en[i]` are both 1 and the LCD does not own the pin, `pin_oe[i]` is 1 and the source select is 2'b01 (timer). A pin with `tmr_oc_en[i]` = 0 (input capture or unused) follows its direction bit.
- R9: If LCD ownership and timer output compare are both active on one pin, the LCD takes precedence.
- R10: Reads from offsets other than 1 and 2 return zero, and writes to them change nothing.
- R11: The source select for pin i sits at bits [2i+1:2i] of `pin_src`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Register offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data for the current offset (combinational) |
| lcd_module_en | input | 1 | LCD driver module enabled |
| lcd_seg_en | input | WIDTH | Per-pin LCD segment enable |
| tmr_module_en | input | 1 | Timer module enabled |
| tmr_oc_en | input | WIDTH | Per-pin output-compare enable |
| pin_in | input | WIDTH | Raw pin levels |
| pin_oe | output | WIDTH | Per-pin digital output enable |
| pin_src | output | 2*WIDTH | Per-pin output source select |

## Verification
The bench builds the block with its defaults: WIDTH 8, ADDR_W 4 and two synchronizer stages. An 8-bit port lets each vector mix software-owned, LCD-owned, timer-owned and contested pins in one pattern. The 4-bit offset space leaves offset 0 and offsets 3 to 15 unmapped, so the zero-read and ignored-write rules can be probed at both ends. Two stages fix the readback latency at two edges, which the bench samples just past.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    SRC_GPIO  = 2'b00,
    SRC_TIMER = 2'b01,
    SRC_LCD   = 2'b10
  } pin_src_e;

  localparam int unsigned OFS_INPUT = 1;
  localparam int unsigned OFS_DIR   = 2;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] pin_raw,
  output logic [WIDTH-1:0] pin_sync
);
  // No reset: these flops only mirror the live pin levels.
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) stage_q[0] <= pin_raw;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) stage_q[s] <= stage_q[s-1];
  end

  assign pin_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_dir_reg.sv
module gpio_dir_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] dir_q
);
  logic [WIDTH-1:0] dir_d;

  always_comb begin
    dir_d = dir_q;
    if (wr_en) dir_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_q <= '0;
    else        dir_q <= dir_d;
  end

  // R3/R10: without a decoded write the register keeps its value
  assert_dir_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(dir_q));
  assert_dir_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> dir_q == $past(wdata));
endmodule

// File: rtl/gpio_pin_arbiter.sv
module gpio_pin_arbiter
  import gpio_pkg::*;
(
  input  logic     lcd_own,
  input  logic     oc_own,
  input  logic     dir_bit,
  input  logic     pin_lvl,
  output logic     oe,
  output pin_src_e src,
  output logic     rd_bit
);
  always_comb begin
    oe     = dir_bit;
    src    = SRC_GPIO;
    rd_bit = pin_lvl;
    if (lcd_own) begin
      oe     = 1'b0;
      src    = SRC_LCD;
      rd_bit = 1'b1;
    end else if (oc_own) begin
      oe  = 1'b1;
      src = SRC_TIMER;
    end
  end
endmodule

// File: rtl/gpio_override_port.sv
module gpio_override_port
  import gpio_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [WIDTH-1:0]   bus_wdata,
  output logic [WIDTH-1:0]   bus_rdata,
  input  logic               lcd_module_en,
  input  logic [WIDTH-1:0]   lcd_seg_en,
  input  logic               tmr_module_en,
  input  logic [WIDTH-1:0]   tmr_oc_en,
  input  logic [WIDTH-1:0]   pin_in,
  output logic [WIDTH-1:0]   pin_oe,
  output logic [2*WIDTH-1:0] pin_src
);
  localparam logic [ADDR_W-1:0] ADDR_INPUT = ADDR_W'(OFS_INPUT);
  localparam logic [ADDR_W-1:0] ADDR_DIR   = ADDR_W'(OFS_DIR);

  logic             rst_n_sync;
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] rd_view;
  logic             dir_wr;
  logic [WIDTH-1:0] lcd_own;
  logic [WIDTH-1:0] oc_own;

  gpio_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync));

  gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .pin_raw(pin_in), .pin_sync(pin_sync));

  always_comb dir_wr = bus_we && (bus_addr == ADDR_DIR);

  gpio_dir_reg #(.WIDTH(WIDTH)) u_dir (
    .clk(clk), .rst_n(rst_n_sync), .wr_en(dir_wr),
    .wdata(bus_wdata), .dir_q(dir_q));

  always_comb begin
    lcd_own = lcd_module_en ? lcd_seg_en : '0;
    oc_own  = tmr_module_en ? tmr_oc_en  : '0;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    pin_src_e src_i;

    gpio_pin_arbiter u_arb (
      .lcd_own(lcd_own[i]), .oc_own(oc_own[i]), .dir_bit(dir_q[i]),
      .pin_lvl(pin_sync[i]), .oe(pin_oe[i]), .src(src_i),
      .rd_bit(rd_view[i]));

    assign pin_src[2*i +: 2] = src_i;

    assert_lcd_drops_oe_R7: assert property (@(posedge clk) disable iff (!rst_n_sync)
      (lcd_module_en && lcd_seg_en[i]) |-> !pin_oe[i]);
    assert_oc_forces_out_R8: assert property (@(posedge clk) disable iff (!rst_n_sync)
      (tmr_module_en && tmr_oc_en[i] && !(lcd_module_en && lcd_seg_en[i])) |-> pin_oe[i]);
    assert_lcd_wins_R9: assert property (@(posedge clk) disable iff (!rst_n_sync)
      (lcd_module_en && lcd_seg_en[i] && tmr_module_en && tmr_oc_en[i])
        |-> pin_src[2*i +: 2] == SRC_LCD);
    assert_lcd_reads_one_R2: assert property (@(posedge clk) disable iff (!rst_n_sync)
      (lcd_module_en && lcd_seg_en[i] && bus_addr == ADDR_INPUT) |-> bus_rdata[i]);
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_INPUT)    bus_rdata = rd_view;
    else if (bus_addr == ADDR_DIR) bus_rdata = dir_q;
  end

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (bus_addr != ADDR_INPUT && bus_addr != ADDR_DIR) |-> bus_rdata == '0);
endmodule

// File: tb/tb_gpio_override_port.sv
module tb_gpio_override_port;
  localparam int WIDTH  = 8;
  localparam int ADDR_W = 4;

  logic               clk = 1'b0;
  logic               rst_n;
  logic [ADDR_W-1:0]  bus_addr;
  logic               bus_we;
  logic [WIDTH-1:0]   bus_wdata;
  logic [WIDTH-1:0]   bus_rdata;
  logic               lcd_module_en;
  logic [WIDTH-1:0]   lcd_seg_en;
  logic               tmr_module_en;
  logic [WIDTH-1:0]   tmr_oc_en;
  logic [WIDTH-1:0]   pin_in;
  logic [WIDTH-1:0]   pin_oe;
  logic [2*WIDTH-1:0] pin_src;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;  // 50 MHz

  gpio_override_port #(.WIDTH(WIDTH), .ADDR_W(ADDR_W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lcd_module_en(lcd_module_en), .lcd_seg_en(lcd_seg_en),
    .tmr_module_en(tmr_module_en), .tmr_oc_en(tmr_oc_en),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_src(pin_src));

  // {lcd_mod, lcd_seg, tmr_mod, tmr_oc, dir, pin, exp_oe, exp_src, exp_in}
  typedef struct packed {
    logic        lcd_mod;
    logic [7:0]  lcd_seg;
    logic        tmr_mod;
    logic [7:0]  tmr_oc;
    logic [7:0]  dir;
    logic [7:0]  pin;
    logic [7:0]  exp_oe;
    logic [15:0] exp_src;
    logic [7:0]  exp_in;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 8'hFF, 1'b0, 8'hFF, 8'hA5, 8'h3C, 8'hA5, 16'h0000, 8'h3C},
    '{1'b1, 8'hF0, 1'b0, 8'h00, 8'h0F, 8'h00, 8'h0F, 16'hAA00, 8'hF0},
    '{1'b0, 8'h00, 1'b1, 8'h0F, 8'h00, 8'hFF, 8'h0F, 16'h0055, 8'hFF},
    '{1'b1, 8'h3C, 1'b1, 8'h0F, 8'hC0, 8'h81, 8'hC3, 16'h0AA5, 8'hBD},
    '{1'b1, 8'h00, 1'b1, 8'h00, 8'h55, 8'h5A, 8'h55, 16'h0000, 8'h5A},
    '{1'b0, 8'hFF, 1'b1, 8'h80, 8'h01, 8'hAA, 8'h81, 16'h4000, 8'hAA}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [WIDTH-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [WIDTH-1:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin : main
    logic [WIDTH-1:0] rd;
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    lcd_module_en = 1'b0; lcd_seg_en = '0; tmr_module_en = 1'b0; tmr_oc_en = '0;
    pin_in = 8'h3C;

    // R4: readback follows pins while reset is held
    settle();
    bus_read(4'd1, rd);
    check("R4 readback during reset", 16'(rd), 16'h003C);
    pin_in = 8'hC3;
    settle();
    bus_read(4'd1, rd);
    check("R4 readback tracks pins in reset", 16'(rd), 16'h00C3);

    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R5/R6: reset state
    bus_read(4'd2, rd);
    check("R5 direction reset value", 16'(rd), 16'h0000);
    check("R6 oe after reset", 16'(pin_oe), 16'h0000);
    check("R11 src after reset", pin_src, 16'h0000);

    // Vector table: R1 R2 R6 R7 R8 R9 R11
    for (int v = 0; v < NVEC; v++) begin
      lcd_module_en = VECS[v].lcd_mod; lcd_seg_en = VECS[v].lcd_seg;
      tmr_module_en = VECS[v].tmr_mod; tmr_oc_en = VECS[v].tmr_oc;
      pin_in = VECS[v].pin;
      bus_write(4'd2, VECS[v].dir);
      settle();
      check($sformatf("R6/R7/R8/R9 oe vec%0d", v), 16'(pin_oe), 16'(VECS[v].exp_oe));
      check($sformatf("R11 src vec%0d", v), pin_src, VECS[v].exp_src);
      bus_read(4'd1, rd);
      check($sformatf("R1/R2 readback vec%0d", v), 16'(rd), 16'(VECS[v].exp_in));
      bus_read(4'd2, rd);
      check($sformatf("R5 direction readback vec%0d", v), 16'(rd), 16'(VECS[v].dir));
    end

    // R7: clearing LCD module enable hands pins back to direction bits
    lcd_module_en = 1'b1; lcd_seg_en = 8'hFF; tmr_module_en = 1'b0; tmr_oc_en = '0;
    bus_write(4'd2, 8'h69);
    settle();
    check("R7 lcd owns all oe", 16'(pin_oe), 16'h0000);
    check("R7 lcd owns all src", pin_src, 16'hAAAA);
    lcd_module_en = 1'b0;
    settle();
    check("R7 oe restored", 16'(pin_oe), 16'h0069);

    // R1: latency of the synchronizer
    pin_in = 8'h00;
    settle();
    @(negedge clk); bus_addr = 4'd1; pin_in = 8'hFF;
    @(negedge clk); #1 check("R1 not visible after one edge", 16'(bus_rdata), 16'h0000);
    @(negedge clk); #1 check("R1 visible after two edges", 16'(bus_rdata), 16'h00FF);

    // R3: write to input offset is ignored
    pin_in = 8'h5A;
    bus_write(4'd1, 8'hFF);
    settle();
    bus_read(4'd2, rd);
    check("R3 direction unchanged", 16'(rd), 16'h0069);
    bus_read(4'd1, rd);
    check("R3 readback still pins", 16'(rd), 16'h005A);

    // R10: unmapped offsets
    bus_write(4'd0, 8'hFF);
    bus_write(4'd3, 8'h00);
    bus_write(4'd15, 8'hAA);
    bus_read(4'd2, rd);
    check("R10 direction untouched", 16'(rd), 16'h0069);
    check("R10 oe untouched", 16'(pin_oe), 16'h0069);
    bus_read(4'd0, rd);
    check("R10 offset 0 reads zero", 16'(rd), 16'h0000);
    bus_read(4'd7, rd);
    check("R10 offset 7 reads zero", 16'(rd), 16'h0000);
    bus_read(4'd15, rd);
    check("R10 offset 15 reads zero", 16'(rd), 16'h0000);

    // R5: reset clears direction again
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_read(4'd2, rd);
    check("R5 direction cleared by reset", 16'(rd), 16'h0000);

    finish_run();
  end
endmodule